// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block resolves a 32-bit virtual address into a physical address when the translation buffer misses. It accepts the miss with its access type (read or write) and the privilege of the requester (user or supervisor), then reads two tables from memory. The first is the directory, found at a 4 KB-aligned base frame. The second is a leaf table, whose frame comes from the directory entry. Each table has 1024 entries of 32 bits. The walker checks presence and permission at every level it visits. It then sets the accessed and dirty flags in memory where they change, and finishes with either a buffer fill (physical address plus the final entry) or a fault record.

Memory is reached through one single-word port. The walker raises a request and holds it until the memory returns ready, so it issues one access at a time. A directory entry can map a 4 MB page directly, and then no leaf is read. The fault record says whether the cause was a missing entry or a protection violation. It also carries the virtual address, the access type and the privilege.

Top module: `ptw_core`

## Requirements
- R1: The directory entry is read at address root_base*4096 + va[31:22]*4. The leaf entry is read at dir_entry[31:12]*4096 + va[21:12]*4.
- R2: A walk through a leaf gives done_paddr = {leaf[31:12], va[11:0]}. Alongside it, fill_vpn = va[31:12], fill_large = 0 and fill_entry holds the leaf with its flags updated. All of these are held for a single cycle while done_valid is high.
- R3: A present directory entry with bit 7 set maps a 4 MB page. In that case done_paddr = {dir[31:22], va[21:0]}, fill_large = 1, fill_entry is the updated directory entry, and no leaf read is issued.
- R4: An entry whose bit 0 (present) is 0, at either level, ends the walk with fault_valid and fault_prot = 0. The record also gives fault_vaddr, fault_write and fault_user for the request. When the directory entry is absent, only one read is issued.
- R5: A write where bit 1 (writable) is 0, or a user access where bit 2 (user-allowed) is 0, is a protection fault (fault_prot = 1). This is checked in every entry the walk visits. A directory that fails the check stops the walk before the leaf read, and a supervisor access ignores bit 2.
- R6: A successful walk sets bit 5 (accessed) in every entry it visits. On a write it also sets bit 6 (dirty) in the final entry, which is the leaf, or the directory entry for a 4 MB page.
- R7: An entry is written back only when its value changes, and never on a fault. If both entries change, the directory entry is written before the leaf.
- R8: A memory request keeps its address, direction and write data unchanged until mem_ready is seen, and the walk result does not depend on memory latency.
- R9: req_ready is high only while the walker is idle. A request held or changed during a walk is ignored, and the walk in progress completes for the address first accepted.
- R10: Each accepted request ends with exactly one single-cycle pulse, on either done_valid or fault_valid, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation miss to resolve |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address of the miss |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| root_base | input | 20 | Frame number of the directory, sampled at acceptance |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry value for writes |
| mem_ready | input | 1 | Memory has completed the access |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done_valid | output | 1 | Translation completed |
| done_paddr | output | 32 | Resulting physical address |
| fill_vpn | output | 20 | Virtual page number for the buffer fill |
| fill_entry | output | 32 | Final entry with updated flags |
| fill_large | output | 1 | Fill maps a 4 MB page |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_prot | output | 1 | 1 = protection violation, 0 = entry absent |
| fault_write | output | 1 | Access type of the faulting request |
| fault_user | output | 1 | Privilege of the faulting request |

## Verification
The properties take for granted that memory raises mem_ready only while a request is pending, and that read data is valid in the cycle of ready. The bench memory model follows this rule. It answers after a programmable number of wait cycles and drops ready right after each completed access, so back-to-back write-backs wait again. Requests come in only through the idle handshake. The bench also holds req_valid high with a changed address during a walk, to show that the busy walker does not sample it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_CHK_DIR,
      ST_RD_LEAF,
      ST_CHK_LEAF,
      ST_WB,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

   // flag positions inside a table entry
   localparam int unsigned F_PRESENT = 0;
   localparam int unsigned F_WRITE   = 1;
   localparam int unsigned F_USER    = 2;
   localparam int unsigned F_ACCESS  = 5;
   localparam int unsigned F_DIRTY   = 6;
   localparam int unsigned F_BIG     = 7;

endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
   import ptw_pkg::*;
#(
   parameter int unsigned ENTRY_W = 32
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               is_write,
   input  logic               is_user,
   input  logic               mark_dirty,
   output logic               absent,
   output logic               denied,
   output logic [ENTRY_W-1:0] next_entry,
   output logic               changed
);
   always_comb begin
      absent     = ~entry[F_PRESENT];
      denied     = (is_write & ~entry[F_WRITE]) | (is_user & ~entry[F_USER]);
      next_entry = entry;
      next_entry[F_ACCESS] = 1'b1;
      if (mark_dirty) next_entry[F_DIRTY] = 1'b1;
      changed    = (next_entry != entry);
   end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned IDX_W   = 10,
   parameter int unsigned OFS_W   = 12
) (
   input  logic [VA_W-OFS_W-1:0] root_frame,
   input  logic [VA_W-1:0]       vaddr,
   input  logic [VA_W-1:0]       dir_entry,
   input  logic [VA_W-1:0]       leaf_entry,
   output logic [VA_W-1:0]       dir_addr,
   output logic [VA_W-1:0]       leaf_addr,
   output logic [VA_W-1:0]       small_pa,
   output logic [VA_W-1:0]       big_pa
);
   localparam int unsigned SLOT_W = OFS_W - IDX_W;
   localparam int unsigned BIG_W  = IDX_W + OFS_W;

   if (SLOT_W != 2) begin : g_bad_slot
      $error("ptw_addr_gen: a table of 2**IDX_W words must fill one page");
   end

   logic [IDX_W-1:0] idx_hi;
   logic [IDX_W-1:0] idx_lo;

   always_comb begin
      idx_hi    = vaddr[VA_W-1 -: IDX_W];
      idx_lo    = vaddr[OFS_W +: IDX_W];
      dir_addr  = {root_frame, idx_hi, {SLOT_W{1'b0}}};
      leaf_addr = {dir_entry[VA_W-1:OFS_W], idx_lo, {SLOT_W{1'b0}}};
      small_pa  = {leaf_entry[VA_W-1:OFS_W], vaddr[OFS_W-1:0]};
      big_pa    = {dir_entry[VA_W-1:BIG_W], vaddr[BIG_W-1:0]};
   end
endmodule

// File: rtl/ptw_core.sv
module ptw_core
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W     = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned OFS_W    = 12,
   parameter bit          LARGE_EN = 1'b1,
   localparam int unsigned FRAME_W = VA_W - OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic               req_user,
   input  logic [FRAME_W-1:0] root_base,
   output logic               mem_req,
   output logic               mem_we,
   output logic [VA_W-1:0]    mem_addr,
   output logic [VA_W-1:0]    mem_wdata,
   input  logic               mem_ready,
   input  logic [VA_W-1:0]    mem_rdata,
   output logic               done_valid,
   output logic [VA_W-1:0]    done_paddr,
   output logic [FRAME_W-1:0] fill_vpn,
   output logic [VA_W-1:0]    fill_entry,
   output logic               fill_large,
   output logic               fault_valid,
   output logic [VA_W-1:0]    fault_vaddr,
   output logic               fault_prot,
   output logic               fault_write,
   output logic               fault_user
);
   if (VA_W != 2 * IDX_W + OFS_W) begin : g_bad_split
      $error("ptw_core: two indices and the offset must cover the address");
   end

   walk_state_e        state;
   logic [VA_W-1:0]    va_q, dir_q, leaf_q;
   logic [FRAME_W-1:0] root_q;
   logic               wr_q, usr_q, big_q, prot_q;
   logic               dir_wb_q, leaf_wb_q;

   logic [VA_W-1:0] dir_addr, leaf_addr, small_pa, big_pa;
   logic [VA_W-1:0] dir_next, leaf_next;
   logic            dir_absent, dir_denied, dir_changed;
   logic            leaf_absent, leaf_denied, leaf_changed;
   logic            big_sel;

   if (LARGE_EN) begin : g_large
      assign big_sel = dir_q[F_BIG];
   end else begin : g_small_only
      assign big_sel = 1'b0;
   end

   ptw_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
      .root_frame (root_q),
      .vaddr      (va_q),
      .dir_entry  (dir_q),
      .leaf_entry (leaf_q),
      .dir_addr   (dir_addr),
      .leaf_addr  (leaf_addr),
      .small_pa   (small_pa),
      .big_pa     (big_pa)
   );

   ptw_entry_eval #(.ENTRY_W(VA_W)) u_dir_eval (
      .entry      (dir_q),
      .is_write   (wr_q),
      .is_user    (usr_q),
      .mark_dirty (wr_q & big_sel),
      .absent     (dir_absent),
      .denied     (dir_denied),
      .next_entry (dir_next),
      .changed    (dir_changed)
   );

   ptw_entry_eval #(.ENTRY_W(VA_W)) u_leaf_eval (
      .entry      (leaf_q),
      .is_write   (wr_q),
      .is_user    (usr_q),
      .mark_dirty (wr_q),
      .absent     (leaf_absent),
      .denied     (leaf_denied),
      .next_entry (leaf_next),
      .changed    (leaf_changed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         va_q      <= '0;
         dir_q     <= '0;
         leaf_q    <= '0;
         root_q    <= '0;
         wr_q      <= 1'b0;
         usr_q     <= 1'b0;
         big_q     <= 1'b0;
         prot_q    <= 1'b0;
         dir_wb_q  <= 1'b0;
         leaf_wb_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               va_q      <= req_vaddr;
               wr_q      <= req_write;
               usr_q     <= req_user;
               root_q    <= root_base;
               big_q     <= 1'b0;
               dir_wb_q  <= 1'b0;
               leaf_wb_q <= 1'b0;
               state     <= ST_RD_DIR;
            end
            ST_RD_DIR: if (mem_ready) begin
               dir_q <= mem_rdata;
               state <= ST_CHK_DIR;
            end
            ST_CHK_DIR: begin
               if (dir_absent) begin
                  prot_q <= 1'b0;
                  state  <= ST_FAULT;
               end else if (dir_denied) begin
                  prot_q <= 1'b1;
                  state  <= ST_FAULT;
               end else if (big_sel) begin
                  dir_q    <= dir_next;
                  dir_wb_q <= dir_changed;
                  big_q    <= 1'b1;
                  state    <= dir_changed ? ST_WB : ST_DONE;
               end else begin
                  state <= ST_RD_LEAF;
               end
            end
            ST_RD_LEAF: if (mem_ready) begin
               leaf_q <= mem_rdata;
               state  <= ST_CHK_LEAF;
            end
            ST_CHK_LEAF: begin
               if (leaf_absent) begin
                  prot_q <= 1'b0;
                  state  <= ST_FAULT;
               end else if (leaf_denied) begin
                  prot_q <= 1'b1;
                  state  <= ST_FAULT;
               end else begin
                  dir_q     <= dir_next;
                  leaf_q    <= leaf_next;
                  dir_wb_q  <= dir_changed;
                  leaf_wb_q <= leaf_changed;
                  state     <= (dir_changed | leaf_changed) ? ST_WB : ST_DONE;
               end
            end
            ST_WB: if (mem_ready) begin
               if (dir_wb_q) dir_wb_q <= 1'b0;
               else          leaf_wb_q <= 1'b0;
               if (!(dir_wb_q && leaf_wb_q)) state <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (state == ST_IDLE);
      mem_req   = (state == ST_RD_DIR) || (state == ST_RD_LEAF) || (state == ST_WB);
      mem_we    = (state == ST_WB);
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_RD_DIR:  mem_addr = dir_addr;
         ST_RD_LEAF: mem_addr = leaf_addr;
         ST_WB: begin
            mem_addr  = dir_wb_q ? dir_addr : leaf_addr;
            mem_wdata = dir_wb_q ? dir_q : leaf_q;
         end
         default: ;
      endcase
   end

   assign done_valid  = (state == ST_DONE);
   assign done_paddr  = big_q ? big_pa : small_pa;
   assign fill_vpn    = va_q[VA_W-1:OFS_W];
   assign fill_entry  = big_q ? dir_q : leaf_q;
   assign fill_large  = big_q;
   assign fault_valid = (state == ST_FAULT);
   assign fault_vaddr = va_q;
   assign fault_prot  = prot_q;
   assign fault_write = wr_q;
   assign fault_user  = usr_q;

endmodule

// File: rtl/ptw_core_chk.sv
module ptw_core_chk #(
   parameter int unsigned VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            mem_req,
   input logic            mem_we,
   input logic [VA_W-1:0] mem_addr,
   input logic [VA_W-1:0] mem_wdata,
   input logic            mem_ready,
   input logic            done_valid,
   input logic            fault_valid
);
   // R8
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R6
   wb_sets_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);

   // R7
   no_wb_before_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !$past(mem_we));

   // R9
   idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   // R10
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_valid, fault_valid, mem_req}));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R4
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid);
endmodule

bind ptw_core ptw_core_chk #(.VA_W(VA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ready   (mem_ready),
   .done_valid  (done_valid),
   .fault_valid (fault_valid)
);

// File: tb/ptw_core_bench.sv
`timescale 1ns/1ps
module ptw_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [19:0] root_base = 20'h00010;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid, fill_large, fault_valid, fault_prot, fault_write, fault_user;
   logic [31:0] done_paddr, fill_entry, fault_vaddr;
   logic [19:0] fill_vpn;

   ptw_core u_ptw_core (.*);

   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   int lat = 0;
   int wait_cnt = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int cyc = 0;
   logic [31:0] rd_log [4];
   logic [31:0] wr_log [4];
   logic [31:0] mem_m [logic [31:0]];

   // got_* capture the outcome of the last walk
   logic        got_done, got_fault, got_prot, got_w, got_u, got_large;
   logic [31:0] got_pa, got_entry, got_fva;
   logic [19:0] got_vpn;

   // memory model: ready after lat wait cycles, then dropped for one cycle
   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         mem_ready <= 1'b0;
         if (mem_we) begin
            mem_m[mem_addr] = mem_wdata;
            if (wr_cnt < 4) wr_log[wr_cnt] = mem_addr;
            wr_cnt = wr_cnt + 1;
         end else begin
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
            rd_cnt = rd_cnt + 1;
         end
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ready <= 1'b1;
            mem_rdata <= mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
            wait_cnt  = 0;
         end else begin
            wait_cnt = wait_cnt + 1;
         end
      end
   end

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem_m.exists(a) ? mem_m[a] : 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, input logic w, input logic u, input logic [31:0] alt_va);
      int n;
      rd_cnt = 0; wr_cnt = 0;
      got_done = 0; got_fault = 0;
      @(negedge clk);
      req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
      @(negedge clk);
      // alt_va != va: keep req_valid up with another address while busy
      if (alt_va != va) begin
         req_vaddr = alt_va;
         chk("R9 ready low while busy", {31'b0, req_ready}, 32'd0);
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!(done_valid || fault_valid) && n < 300) begin
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      if (n >= 300) begin
         bad++; total++;
         $display("FAIL R10: walk timeout actual=none expected=outcome");
      end
      got_done = done_valid; got_fault = fault_valid;
      got_pa = done_paddr; got_entry = fill_entry; got_vpn = fill_vpn; got_large = fill_large;
      got_fva = fault_vaddr; got_prot = fault_prot; got_w = fault_write; got_u = fault_user;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R9 reset ready", {31'b0, req_ready}, 32'd1);
      chk("R8 reset no request", {31'b0, mem_req}, 32'd0);
      chk("R10 reset no outcome", {30'b0, done_valid, fault_valid}, 32'd0);
   endtask

   task automatic t_small_read;
      walk(32'h0040_3ABC, 1'b0, 1'b1, 32'h0040_3ABC);
      chk("R1 dir addr", rd_log[0], 32'h0001_0004);
      chk("R1 leaf addr", rd_log[1], 32'h0002_000C);
      chk("R2 done", {31'b0, got_done}, 32'd1);
      chk("R2 paddr", got_pa, 32'h1234_5ABC);
      chk("R2 vpn", {12'b0, got_vpn}, 32'h0000_0403);
      chk("R2 fill entry", got_entry, 32'h1234_5027);
      chk("R6 dir accessed", peek(32'h0001_0004), 32'h0002_0027);
      chk("R6 leaf accessed no dirty", peek(32'h0002_000C), 32'h1234_5027);
      chk("R7 two writes", wr_cnt, 2);
      chk("R7 dir written first", wr_log[0], 32'h0001_0004);
   endtask

   task automatic t_small_write;
      walk(32'h0040_3ABC, 1'b1, 1'b1, 32'h0040_3ABC);
      chk("R6 leaf dirty", peek(32'h0002_000C), 32'h1234_5067);
      chk("R7 only leaf written", wr_cnt, 1);
      chk("R7 leaf addr written", wr_log[0], 32'h0002_000C);
      walk(32'h0040_3ABC, 1'b1, 1'b0, 32'h0040_3ABC);
      chk("R7 no write when unchanged", wr_cnt, 0);
      chk("R2 repeat paddr", got_pa, 32'h1234_5ABC);
   endtask

   task automatic t_absent;
      walk(32'h0040_4123, 1'b1, 1'b0, 32'h0040_4123);
      chk("R4 leaf absent fault", {30'b0, got_fault, got_prot}, 32'd2);
      chk("R4 fault vaddr", got_fva, 32'h0040_4123);
      chk("R4 fault type", {30'b0, got_w, got_u}, 32'd2);
      chk("R7 no write on fault", wr_cnt, 0);
      walk(32'h0080_0010, 1'b0, 1'b1, 32'h0080_0010);
      chk("R4 dir absent fault", {30'b0, got_fault, got_prot}, 32'd2);
      chk("R4 single read", rd_cnt, 1);
      chk("R4 fault type user read", {30'b0, got_w, got_u}, 32'd1);
   endtask

   task automatic t_protect;
      walk(32'h0040_5008, 1'b1, 1'b1, 32'h0040_5008);
      chk("R5 write to read-only", {30'b0, got_fault, got_prot}, 32'd3);
      chk("R7 read-only entry untouched", peek(32'h0002_0014), 32'h3333_3005);
      walk(32'h0040_6044, 1'b0, 1'b1, 32'h0040_6044);
      chk("R5 user on supervisor page", {30'b0, got_fault, got_prot}, 32'd3);
      walk(32'h0040_6044, 1'b0, 1'b0, 32'h0040_6044);
      chk("R5 supervisor allowed", got_pa, 32'h4444_4044);
      walk(32'h00C0_0000, 1'b0, 1'b1, 32'h00C0_0000);
      chk("R5 directory denies", {30'b0, got_fault, got_prot}, 32'd3);
      chk("R5 no leaf read", rd_cnt, 1);
   endtask

   task automatic t_large;
      walk(32'h0101_2345, 1'b1, 1'b0, 32'h0101_2345);
      chk("R3 paddr", got_pa, 32'h0AC1_2345);
      chk("R3 single read", rd_cnt, 1);
      chk("R3 large flag", {31'b0, got_large}, 32'd1);
      chk("R6 large dirty", peek(32'h0001_0010), 32'h0AC0_00E7);
      chk("R3 fill entry", got_entry, 32'h0AC0_00E7);
   endtask

   task automatic t_latency_busy;
      lat = 3;
      walk(32'h0040_7010, 1'b1, 1'b0, 32'h0040_7010);
      chk("R8 slow paddr", got_pa, 32'h5555_5010);
      chk("R8 slow dirty", peek(32'h0002_001C), 32'h5555_5067);
      lat = 1;
      walk(32'h0040_3ABC, 1'b0, 1'b0, 32'h0080_0000);
      chk("R9 first address kept", got_pa, 32'h1234_5ABC);
      chk("R9 outcome done", {30'b0, got_done, got_fault}, 32'd2);
      lat = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<100000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      mem_m[32'h0001_0004] = 32'h0002_0007;
      mem_m[32'h0002_000C] = 32'h1234_5007;
      mem_m[32'h0002_0014] = 32'h3333_3005;
      mem_m[32'h0002_0018] = 32'h4444_4003;
      mem_m[32'h0002_001C] = 32'h5555_5007;
      mem_m[32'h0001_000C] = 32'h0003_0001;
      mem_m[32'h0001_0010] = 32'h0AC0_0087;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_small_read();
      t_small_write();
      t_absent();
      t_protect();
      t_large();
      t_latency_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule